// File: doc/BRIEF.md
# Transmit Burst Ramp Controller

This block sequences a baseband transmitter through a complete burst. After power is enabled it waits out a fixed offset-calibration interval and then raises a ready flag. A burst request taken while ready starts a short lead-in. After the lead-in a bit clock runs for the whole burst. A per-sample envelope gain rises along a raised-cosine curve over three symbols, stays at full scale while data flows, and falls along the mirrored curve once the request is withdrawn. The clock keeps running for extra trailing symbols so that a downstream pulse-shaping filter can empty.

The gain is multiplied into the I and Q samples with rounding. A copy of the burst request, delayed by the full transmit pipeline latency, is provided for switching an RF power amplifier. Taking the power enable low puts everything into a quiet sleep state at once.

All timing is counted in master-clock cycles. The default parameters give one bit period of 64 cycles, eight envelope samples per two-bit symbol, a 10-bit gain and a 480-cycle burst-out delay.

Top module: `burst_ramp_ctrl`

## Requirements
- R1: While reset is high, and on every clock edge that samples `pwr_en` low, the next outputs are all zero: `ready`, `bit_clk`, `gain`, `burst_out`, `i_out` and `q_out`.
- R2: The first edge that samples `pwr_en` high after sleep starts calibration. `ready` goes high exactly CAL_CYC edges later and not before.
- R3: An edge that samples `burst_req` high while `ready` is high drops `ready` at that same edge. A request while `ready` is low has no effect: it starts no bit clock and leaves calibration timing unchanged.
- R4: `bit_clk` first goes high at the third edge after the start edge. It is a square wave of BIT_CYC cycles, high for the first half. Two bit periods make one symbol (SYM = 2*BIT_CYC cycles), counted from symbol 0.
- R5: In symbols 0 to 2, `gain` equals up(k) = round(FS*(1-cos(pi*k/(3*SPS)))/2), with FS = 2^(GW-1). Here k = 3-symbol sample index = symbol*SPS + (cycle within symbol)/(SYM/SPS).
- R6: From symbol 3 until the release takes effect, `gain` holds FS.
- R7: A request sampled low during symbol F ends the burst. F is never below 2: an earlier drop takes effect in symbol 2. Symbol F completes unchanged, and exactly four further symbols (eight bit periods) of `bit_clk` follow.
- R8: In symbols F+1, F+2 and F+3, `gain` equals FS - up(k), with k counted from 0 at the start of symbol F+1. In symbol F+4 `gain` is zero.
- R9: At the edge that ends symbol F+4, `ready` rises while `bit_clk` and `gain` are zero, and a new burst may start.
- R10: `i_out` and `q_out` equal floor((x*g + FS/2)/FS) one edge after the two's complement input x and the gain value g present before that edge.
- R11: `burst_out` equals `burst_req` as sampled OUT_DLY edges earlier, and is zero for the first OUT_DLY edges after waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Power enable; low means sleep |
| burst_req | input | 1 | Burst request level |
| i_in | input | DW | In-phase sample, two's complement |
| q_in | input | DW | Quadrature sample, two's complement |
| ready | output | 1 | Calibrated and idle, burst may start |
| bit_clk | output | 1 | Transmit bit clock |
| gain | output | GW | Envelope gain, FS = unity |
| burst_out | output | 1 | Delayed burst request for the RF amplifier |
| i_out | output | DW | Envelope-scaled in-phase sample |
| q_out | output | DW | Envelope-scaled quadrature sample |

## Verification
The assertions check on every cycle the properties that hold at all times. Sleep silences every output on the next edge. A start request drops ready at once. Gain never exceeds unity, and ready is never high while the clock or gain is active. Zero gain forces zero samples, and the bit clock never starts while ready. The bench scenarios cover the properties that need counted history: the exact calibration length, the position of each ramp sample against the symbol count, and the release symbol with its four-symbol tail, including a drop during the lead-in. They also cover the 480-edge burst-out delay and recovery from a power loss in the middle of a burst.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_CAL,
    ST_RDY,
    ST_LEAD,
    ST_ACT
  } brc_state_e;

  localparam real BRC_PI = 3.14159265358979;
endpackage

// File: rtl/brc_env_lut.sv
// Raised-cosine rising envelope table, computed at elaboration.
module brc_env_lut #(
  parameter int GW = 10,
  parameter int N  = 24
) (
  input  logic [$clog2(N)-1:0] idx,
  output logic [GW-1:0]        val
);
  localparam int FS = 1 << (GW - 1);

  logic [GW-1:0] tbl [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam real ANG = brc_pkg::BRC_PI * real'(g) / real'(N);
    localparam int  VAL = int'(real'(FS) * (1.0 - $cos(ANG)) / 2.0);
    assign tbl[g] = GW'(VAL);
  end

  always_comb val = (int'(idx) < N) ? tbl[idx] : '0;
endmodule

// File: rtl/brc_seq.sv
// Burst sequencer: sleep, calibration, ready, lead-in, active with release tail.
module brc_seq
  import brc_pkg::*;
#(
  parameter int BIT_CYC  = 64,
  parameter int SPS      = 8,
  parameter int GW       = 10,
  parameter int CAL_CYC  = 4096,
  parameter int LEAD_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_en,
  input  logic          burst_req,
  output logic          ready,
  output logic          bit_clk,
  output logic [GW-1:0] gain
);
  localparam int SYM_CYC  = 2 * BIT_CYC;
  localparam int SAMP_CYC = SYM_CYC / SPS;
  localparam int HALF     = BIT_CYC / 2;
  localparam int RAMP_N   = 3 * SPS;
  localparam int FS       = 1 << (GW - 1);
  localparam int CW       = $clog2(SYM_CYC);
  localparam int TW       = $clog2(CAL_CYC + LEAD_CYC + 1);
  localparam int KW       = $clog2(RAMP_N);

  brc_state_e     st, st_n;
  logic [TW-1:0]  cnt, cnt_n;
  logic [CW-1:0]  cyc, cyc_n;
  logic [1:0]     sc, sc_n;     // symbol count, saturates at 3
  logic           rel, rel_n;   // release seen
  logic [2:0]     rem, rem_n;   // trailing symbols left
  logic           wrap;
  logic           up_ph;
  int             k_c, sp_c;
  logic [KW-1:0]  lut_idx;
  logic [GW-1:0]  lut_val;
  logic [GW-1:0]  gain_n;
  logic           bclk_n, ready_n;

  // next-state sequencing
  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    cyc_n = cyc;
    sc_n  = sc;
    rel_n = rel;
    rem_n = rem;
    wrap  = (cyc == CW'(SYM_CYC - 1));
    if (!pwr_en) begin
      st_n  = ST_SLEEP;
      cnt_n = '0;
      cyc_n = '0;
      sc_n  = '0;
      rel_n = 1'b0;
      rem_n = 3'd4;
    end else begin
      case (st)
        ST_SLEEP: begin
          st_n  = ST_CAL;
          cnt_n = '0;
        end
        ST_CAL: begin
          if (cnt == TW'(CAL_CYC - 1)) st_n = ST_RDY;
          else cnt_n = cnt + 1'b1;
        end
        ST_RDY: begin
          if (burst_req) begin
            st_n  = ST_LEAD;
            cnt_n = '0;
          end
        end
        ST_LEAD: begin
          if (cnt == TW'(LEAD_CYC - 1)) begin
            st_n  = ST_ACT;
            cyc_n = '0;
            sc_n  = '0;
            rel_n = 1'b0;
            rem_n = 3'd4;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_ACT: begin
          cyc_n = wrap ? '0 : cyc + 1'b1;
          if (wrap && sc != 2'd3) sc_n = sc + 1'b1;
          if (rel && wrap) begin
            if (rem == 3'd0) st_n = ST_RDY;
            else rem_n = rem - 3'd1;
          end
          if (!rel && !burst_req && sc >= 2'd2) begin
            rel_n = 1'b1;
            rem_n = 3'd4;
          end
        end
        default: st_n = ST_SLEEP;
      endcase
    end
  end

  // envelope position of the next state
  always_comb begin
    sp_c  = int'(cyc_n) / SAMP_CYC;
    up_ph = !rel_n || (rem_n == 3'd4);
    if (up_ph) k_c = int'(sc_n) * SPS + sp_c;
    else       k_c = (3 - int'(rem_n)) * SPS + sp_c;
    lut_idx = KW'(k_c);
  end

  brc_env_lut #(.GW(GW), .N(RAMP_N)) u_lut (
    .idx (lut_idx),
    .val (lut_val)
  );

  always_comb begin
    if (st_n != ST_ACT)    gain_n = '0;
    else if (up_ph)        gain_n = (sc_n == 2'd3) ? GW'(FS) : lut_val;
    else if (rem_n != 3'd0) gain_n = GW'(FS - int'(lut_val));
    else                   gain_n = '0;
    bclk_n  = (st_n == ST_ACT) && ((int'(cyc_n) % BIT_CYC) < HALF);
    ready_n = (st_n == ST_RDY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_SLEEP;
      cnt     <= '0;
      cyc     <= '0;
      sc      <= '0;
      rel     <= 1'b0;
      rem     <= 3'd4;
      ready   <= 1'b0;
      bit_clk <= 1'b0;
      gain    <= '0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      cyc     <= cyc_n;
      sc      <= sc_n;
      rel     <= rel_n;
      rem     <= rem_n;
      ready   <= ready_n;
      bit_clk <= bclk_n;
      gain    <= gain_n;
    end
  end
endmodule

// File: rtl/brc_scale.sv
// Rounded multiply of one sample channel by the envelope gain.
module brc_scale #(
  parameter int DW = 10,
  parameter int GW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic signed [DW-1:0] x,
  input  logic        [GW-1:0] g,
  output logic signed [DW-1:0] y
);
  localparam int PW = DW + GW + 1;
  localparam logic signed [PW-1:0] RND = PW'(1 << (GW - 2));

  logic signed [PW-1:0] xe, ge, prod, rnd;

  assign xe   = PW'(x);
  assign ge   = $signed(PW'(g));
  assign prod = xe * ge;
  assign rnd  = prod + RND;

  always_ff @(posedge clk) begin
    if (rst || clr) y <= '0;
    else            y <= DW'(rnd >>> (GW - 1));
  end
endmodule

// File: rtl/brc_delay.sv
// Fixed delay line in a circular single-bit memory.
module brc_delay #(
  parameter int DLY = 480
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  localparam int AW = $clog2(DLY);

  logic          mem [DLY];
  logic [AW-1:0] ptr;
  logic          full;

  always_ff @(posedge clk) begin
    if (en && !rst) mem[ptr] <= d;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ptr  <= '0;
      full <= 1'b0;
      q    <= 1'b0;
    end else begin
      q <= full & mem[ptr];
      if (ptr == AW'(DLY - 1)) begin
        ptr  <= '0;
        full <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_ramp_ctrl.sv
module burst_ramp_ctrl #(
  parameter int BIT_CYC  = 64,
  parameter int SPS      = 8,
  parameter int GW       = 10,
  parameter int DW       = 10,
  parameter int CAL_CYC  = 4096,
  parameter int LEAD_CYC = 3,
  parameter int OUT_DLY  = 480
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pwr_en,
  input  logic                 burst_req,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] q_in,
  output logic                 ready,
  output logic                 bit_clk,
  output logic        [GW-1:0] gain,
  output logic                 burst_out,
  output logic signed [DW-1:0] i_out,
  output logic signed [DW-1:0] q_out
);
  localparam int NCH = 2;

  logic signed [DW-1:0] x_a [NCH];
  logic signed [DW-1:0] y_a [NCH];

  brc_seq #(
    .BIT_CYC (BIT_CYC),
    .SPS     (SPS),
    .GW      (GW),
    .CAL_CYC (CAL_CYC),
    .LEAD_CYC(LEAD_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .pwr_en   (pwr_en),
    .burst_req(burst_req),
    .ready    (ready),
    .bit_clk  (bit_clk),
    .gain     (gain)
  );

  assign x_a[0] = i_in;
  assign x_a[1] = q_in;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    brc_scale #(.DW(DW), .GW(GW)) u_scale (
      .clk(clk),
      .rst(rst),
      .clr(!pwr_en),
      .x  (x_a[c]),
      .g  (gain),
      .y  (y_a[c])
    );
  end

  assign i_out = y_a[0];
  assign q_out = y_a[1];

  brc_delay #(.DLY(OUT_DLY)) u_dly (
    .clk(clk),
    .rst(rst),
    .en (pwr_en),
    .d  (burst_req),
    .q  (burst_out)
  );
endmodule

// File: rtl/burst_ramp_ctrl_chk.sv
module burst_ramp_ctrl_chk #(
  parameter int GW = 10,
  parameter int DW = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 pwr_en,
  input logic                 burst_req,
  input logic                 ready,
  input logic                 bit_clk,
  input logic        [GW-1:0] gain,
  input logic                 burst_out,
  input logic signed [DW-1:0] i_out,
  input logic signed [DW-1:0] q_out
);
  localparam int FS = 1 << (GW - 1);

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> (!ready && !bit_clk && gain == '0)); // R1
  AST_BOUT_SLEEP: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> !burst_out); // R11
  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    (ready && burst_req && pwr_en) |=> !ready); // R3
  AST_GAIN_MAX: assert property (@(posedge clk) disable iff (rst)
    int'(gain) <= FS); // R6
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!bit_clk && gain == '0)); // R9
  AST_CLK_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_clk) |-> !ready); // R4
  AST_ZERO_GAIN_IQ: assert property (@(posedge clk) disable iff (rst)
    (gain == '0) |=> (i_out == '0 && q_out == '0)); // R10
endmodule

bind burst_ramp_ctrl burst_ramp_ctrl_chk #(.GW(GW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_en   (pwr_en),
  .burst_req(burst_req),
  .ready    (ready),
  .bit_clk  (bit_clk),
  .gain     (gain),
  .burst_out(burst_out),
  .i_out    (i_out),
  .q_out    (q_out)
);

// File: tb/test_burst_ramp_ctrl.sv
module test_burst_ramp_ctrl;
  localparam int BIT_CYC = 64;
  localparam int SPS     = 8;
  localparam int GW      = 10;
  localparam int DW      = 10;
  localparam int CAL_CYC = 4096;
  localparam int OUT_DLY = 480;
  localparam int SYM     = 2 * BIT_CYC;
  localparam int SAMP    = SYM / SPS;
  localparam int FS      = 1 << (GW - 1);
  localparam real PI     = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_en = 1'b0;
  logic burst_req = 1'b0;
  logic signed [DW-1:0] i_in = '0;
  logic signed [DW-1:0] q_in = '0;
  logic ready, bit_clk, burst_out;
  logic [GW-1:0] gain;
  logic signed [DW-1:0] i_out, q_out;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_ramp_ctrl i_burst_ramp_ctrl (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .burst_req(burst_req),
    .i_in(i_in), .q_in(q_in), .ready(ready), .bit_clk(bit_clk),
    .gain(gain), .burst_out(burst_out), .i_out(i_out), .q_out(q_out)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int up_g(input int k);
    return int'(real'(FS) * (1.0 - $cos(PI * real'(k) / real'(3 * SPS))) / 2.0);
  endfunction

  function automatic int scale_exp(input int x, input int g);
    return int'($floor((real'(x) * real'(g) + real'(FS / 2)) / real'(FS)));
  endfunction

  // reference for the delayed flag and the scaled samples
  bit rq_hist [1024];
  int wk = -1;
  int exp_b = 0, exp_i = 0, exp_q = 0;

  always @(posedge clk) begin
    if (rst || !pwr_en) begin
      wk = -1; exp_b = 0; exp_i = 0; exp_q = 0;
    end else begin
      wk++;
      rq_hist[wk % 1024] = burst_req;
      exp_b = (wk >= OUT_DLY) ? int'(rq_hist[(wk - OUT_DLY) % 1024]) : 0;
      exp_i = scale_exp(int'(i_in), int'(gain));
      exp_q = scale_exp(int'(q_in), int'(gain));
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      chk(int'(burst_out) == exp_b, "R11 burst_out delay", int'(burst_out), exp_b);
      chk(int'(i_out) == exp_i, "R10 i_out scaling", int'(i_out), exp_i);
      chk(int'(q_out) == exp_q, "R10 q_out scaling", int'(q_out), exp_q);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    i_in = DW'($urandom);
    q_in = DW'($urandom);
  endtask

  // wake from sleep; optionally hold a request during calibration (R3)
  task automatic wake(input bit hold_req);
    pwr_en = 1'b1;
    burst_req = hold_req;
    for (int n = 0; n <= CAL_CYC; n++) begin
      tick();
      if (n == 300) burst_req = 1'b0;
      if (hold_req && n < 300)
        chk(bit_clk == 1'b0, "R3 request ignored during calibration", int'(bit_clk), 0);
      if (n == CAL_CYC - 1) chk(ready == 1'b0, "R2 ready not early", int'(ready), 0);
      if (n == CAL_CYC)     chk(ready == 1'b1, "R2 ready after calibration", int'(ready), 1);
    end
  endtask

  task automatic run_burst(input int nd);
    int f, n_end, t, s, c, sp, eg, eb, er;
    string lg, lb, lr;
    if (nd < 3 || (nd - 3) / SYM < 2) f = 2;
    else f = (nd - 3) / SYM + ((((nd - 3) % SYM) == SYM - 1) ? 1 : 0);
    n_end = 3 + (f + 5) * SYM;
    chk(ready == 1'b1, "R9 ready before burst", int'(ready), 1);
    burst_req = 1'b1;
    for (int n = 0; n <= n_end; n++) begin
      tick();
      t = n - 3;
      s = (t >= 0) ? t / SYM : 0;
      lg = "R5 ramp-up gain"; lb = "R4 bit clock"; lr = "R9 ready";
      if (n == 0) lr = "R3 ready drop on start";
      if (n < 3) begin
        er = 0; eb = 0; eg = 0; lb = "R4 lead-in";
      end else if (n < n_end) begin
        c  = t % SYM;
        sp = c / SAMP;
        er = 0;
        eb = ((c % BIT_CYC) < BIT_CYC / 2) ? 1 : 0;
        if (s > f) lb = "R7 trailing bit clock";
        if (s <= f) begin
          if (s < 3) eg = up_g(s * SPS + sp);
          else begin eg = FS; lg = "R6 full gain"; end
        end else if (s <= f + 3) begin
          eg = FS - up_g((s - f - 1) * SPS + sp); lg = "R8 ramp-down gain";
        end else begin
          eg = 0; lg = "R8 untransmitted symbol";
        end
      end else begin
        er = 1; eb = 0; eg = 0; lb = "R9 idle clock"; lg = "R9 idle gain";
      end
      chk(int'(ready) == er, lr, int'(ready), er);
      chk(int'(bit_clk) == eb, lb, int'(bit_clk), eb);
      chk(int'(gain) == eg, lg, int'(gain), eg);
      if (n == nd) burst_req = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(2024));
    repeat (3) tick();
    chk(ready == 1'b0 && gain == '0, "R1 reset state", int'(gain), 0);
    chk(bit_clk == 1'b0 && burst_out == 1'b0, "R1 reset outputs", int'(bit_clk), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    repeat (5) tick();
    chk(ready == 1'b0, "R1 asleep", int'(ready), 0);

    wake(1'b1);
    repeat (4) tick();
    run_burst(1);                  // drop during lead-in: release in symbol 2 (R7)
    repeat (7) tick();
    run_burst(3 + 6 * SYM + 37);   // drop in symbol 6 (R7)
    for (int b = 0; b < 3; b++) begin
      repeat (int'($urandom_range(2, 40))) tick();
      run_burst(int'($urandom_range(3, 3 + 12 * SYM)));
    end

    // power loss in the middle of a burst (R1), then recalibration (R2)
    burst_req = 1'b1;
    repeat (700) tick();
    pwr_en = 1'b0;
    burst_req = 1'b0;
    tick();
    chk(ready == 1'b0 && bit_clk == 1'b0, "R1 sleep stops clock", int'(bit_clk), 0);
    chk(gain == '0, "R1 sleep clears gain", int'(gain), 0);
    repeat (10) tick();
    wake(1'b0);
    repeat (3) tick();
    run_burst(3 + 4 * SYM + 90);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule